// File: doc/BRIEF.md
# Row and Column Profiler

The profiler takes one image frame from a valid/ready pixel stream, where a start-of-packet flag marks the first pixel and an end-of-packet flag marks the last. While the frame streams in at one pixel per cycle, the block builds two profiles. The horizontal profile holds one sum per image column, taken over all rows. The vertical profile holds one sum per image row, taken over all columns. The frame never has to be stored first.

Once the frame has ended, the block sends the finished profiles on an output stream. The column sums go first, then the row sums, and the last row sum carries the end-of-packet flag. A downstream memory writer places them where a host can fetch them for curve fitting. The frame size comes from run-time configuration inputs, sampled when the start-of-packet pixel is accepted. A frame that ends early is flagged, and its profiles are still sent.

Top module: `prof_profiler`

## Requirements
- R1: Output beats 0..W-1 carry the column sums in column order. Column c is the sum of the pixels at input positions k with k mod W = c and k < W*H, counted from the start-of-packet pixel, which is position 0.
- R2: Output beats W..W+H-1 carry the row sums in row order. Row r is the sum of the pixels at positions k with k div W = r. Each sum is zero-extended to 24 bits and cannot overflow for W, H ≤ 256 with 16-bit pixels.
- R3: Each frame produces exactly W+H output beats. `out_eop` is 1 on the last beat only.
- R4: `in_ready` stays 1 while no frame is being emitted, so pixels are taken at full rate. It is 0 from the cycle after the end-of-packet pixel is accepted until the cycle after the last output beat is accepted.
- R5: Consecutive pixels that land in the same column, as when W = 1, are all accumulated, with no cycle lost.
- R6: An accepted start-of-packet pixel discards all partial sums and counters, including in the middle of a frame. The profiles then hold only the pixels of the new frame.
- R7: When end-of-packet arrives after fewer than W*H pixels, `frame_short` becomes 1 and stays 1 until the next start-of-packet. The W+H beats are still sent, and every column or row that received no pixel reads as 0.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_eop` hold their values.
- R9: `done` is 1 for exactly one cycle, the cycle after the beat with `out_eop` is accepted.
- R10: Beats accepted while idle without start-of-packet, including ones that carry end-of-packet, are dropped. They start no emission.
- R11: After reset, `in_ready` is 1 and `out_valid`, `done` and `frame_short` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 9 | Frame width W, 1..256, sampled at start-of-packet |
| cfg_height | input | 9 | Frame height H, 1..256, sampled at start-of-packet |
| in_valid | input | 1 | Pixel beat valid |
| in_ready | output | 1 | Block accepts a pixel beat |
| in_data | input | 16 | Pixel intensity |
| in_sop | input | 1 | First pixel of a frame |
| in_eop | input | 1 | Last pixel of a frame |
| out_valid | output | 1 | Profile beat valid |
| out_ready | input | 1 | Downstream accepts a profile beat |
| out_data | output | 24 | Column sum or row sum |
| out_eop | output | 1 | Last row sum of the frame |
| done | output | 1 | One-cycle pulse when emission completes |
| frame_short | output | 1 | Last frame ended before W*H pixels |

## Verification
The assertions assume that the configured width and height lie between 1 and 256. They also assume that no frame delivers more than W*H pixels before its end-of-packet: the design drops extra pixels, but that case is not asserted. The stimulus draws frame sizes only inside that range, with a few sizes at the 1 and 256 limits. The only frames that break the pixel count are deliberately short ones, and restarted ones that a fresh start-of-packet cuts off. Output back-pressure and input gaps are random, because the hold and handshake properties must survive any `out_ready` pattern.

// File: rtl/prof_pkg.sv
package prof_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FRAME,
    ST_DRAIN,
    ST_EMIT
  } prof_state_e;

  // Width of an accumulator that sums max_dim pixels of pix_w bits.
  function automatic int acc_width(int pix_w, int max_dim);
    return pix_w + $clog2(max_dim);
  endfunction

endpackage

// File: rtl/prof_ram.sv
// Simple dual-port storage: one write port, one registered read port.
module prof_ram #(
  parameter int DW = 24,
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/prof_col_acc.sv
// Column accumulators: read-modify-write with one-cycle forwarding.
module prof_col_acc #(
  parameter int PIX_W = 16,
  parameter int ACC_W = 24,
  parameter int IDX_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             acc_en,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [PIX_W-1:0] acc_pix,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ACC_W-1:0] rd_sum
);

  logic             s1_valid_q;
  logic [IDX_W-1:0] s1_idx_q;
  logic [PIX_W-1:0] s1_pix_q;
  logic             fwd_valid_q, fwd_valid_d;
  logic [IDX_W-1:0] fwd_idx_q;
  logic [ACC_W-1:0] fwd_sum_q;
  logic [DEPTH-1:0] touched_q, touched_d;
  logic             rd_touch_q;
  logic [ACC_W-1:0] ram_rdata, base, sum;
  logic             ram_re;
  logic [IDX_W-1:0] ram_raddr;

  assign ram_re    = acc_en | rd_en;
  assign ram_raddr = acc_en ? acc_idx : rd_idx;

  prof_ram #(.DW(ACC_W), .AW(IDX_W)) i_ram (
    .clk   (clk),
    .we    (s1_valid_q),
    .waddr (s1_idx_q),
    .wdata (sum),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  // The previous write is not yet visible in ram_rdata: forward it.
  always_comb begin
    if (fwd_valid_q && (fwd_idx_q == s1_idx_q)) base = fwd_sum_q;
    else if (touched_q[s1_idx_q])                base = ram_rdata;
    else                                         base = '0;
    sum = base + ACC_W'(s1_pix_q);
  end

  always_comb begin
    touched_d = touched_q;
    if (s1_valid_q) touched_d[s1_idx_q] = 1'b1;
    if (clear)      touched_d = '0;
    fwd_valid_d = s1_valid_q && !clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q  <= 1'b0;
      s1_idx_q    <= '0;
      s1_pix_q    <= '0;
      fwd_valid_q <= 1'b0;
      fwd_idx_q   <= '0;
      fwd_sum_q   <= '0;
      touched_q   <= '0;
      rd_touch_q  <= 1'b0;
    end else begin
      s1_valid_q  <= acc_en;
      fwd_valid_q <= fwd_valid_d;
      touched_q   <= touched_d;
      if (acc_en) begin
        s1_idx_q <= acc_idx;
        s1_pix_q <= acc_pix;
      end
      if (s1_valid_q) begin
        fwd_idx_q <= s1_idx_q;
        fwd_sum_q <= sum;
      end
      if (rd_en) rd_touch_q <= touched_q[rd_idx];
    end
  end

  assign rd_sum = rd_touch_q ? ram_rdata : '0;

  // R4: emission reads only happen while the input side is stalled.
  p_rd_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !acc_en);

endmodule

// File: rtl/prof_row_acc.sv
// Row accumulator: running sum per row, stored at row end.
module prof_row_acc #(
  parameter int PIX_W = 16,
  parameter int ACC_W = 24,
  parameter int IDX_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             acc_en,
  input  logic [IDX_W-1:0] acc_row,
  input  logic [PIX_W-1:0] acc_pix,
  input  logic             row_end,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ACC_W-1:0] rd_sum
);

  logic [ACC_W-1:0] run_q, run_d, run_sum, ram_rdata;
  logic [DEPTH-1:0] touched_q, touched_d;
  logic             rd_touch_q;
  logic             we;

  assign run_sum = (clear ? '0 : run_q) + ACC_W'(acc_pix);
  assign we      = acc_en && row_end;

  prof_ram #(.DW(ACC_W), .AW(IDX_W)) i_ram (
    .clk   (clk),
    .we    (we),
    .waddr (acc_row),
    .wdata (run_sum),
    .re    (rd_en),
    .raddr (rd_idx),
    .rdata (ram_rdata)
  );

  always_comb begin
    run_d = run_q;
    if (acc_en) run_d = row_end ? '0 : run_sum;
    touched_d = clear ? '0 : touched_q;
    if (we) touched_d[acc_row] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= '0;
      touched_q  <= '0;
      rd_touch_q <= 1'b0;
    end else begin
      run_q     <= run_d;
      touched_q <= touched_d;
      if (rd_en) rd_touch_q <= touched_q[rd_idx];
    end
  end

  assign rd_sum = rd_touch_q ? ram_rdata : '0;

endmodule

// File: rtl/prof_emit.sv
// Output sequencer: W column sums, then H row sums.
module prof_emit #(
  parameter int ACC_W = 24,
  parameter int IDX_W = 8,
  localparam int DIM_W = IDX_W + 1,
  localparam int SEQ_W = DIM_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  output logic             col_rd_en,
  output logic             row_rd_en,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [ACC_W-1:0] col_sum,
  input  logic [ACC_W-1:0] row_sum,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ACC_W-1:0] out_data,
  output logic             out_eop,
  output logic             finished
);

  logic             active_q, active_d;
  logic             inflight_q, inflight_d;
  logic             sel_row_q, sel_row_d;
  logic             last_q, last_d;
  logic [SEQ_W-1:0] idx_q, idx_d, total;
  logic             valid_q, valid_d, eop_q, eop_d;
  logic [ACC_W-1:0] data_q, data_d;
  logic             issue, is_row;

  assign total    = SEQ_W'(width) + SEQ_W'(height);
  assign is_row   = idx_q >= SEQ_W'(width);
  assign issue    = active_q && !inflight_q && (!valid_q || out_ready) && (idx_q < total);
  assign rd_idx   = is_row ? IDX_W'(idx_q - SEQ_W'(width)) : IDX_W'(idx_q);
  assign col_rd_en = issue && !is_row;
  assign row_rd_en = issue && is_row;
  assign finished = valid_q && out_ready && eop_q;

  always_comb begin
    active_d   = active_q;
    inflight_d = inflight_q;
    sel_row_d  = sel_row_q;
    last_d     = last_q;
    idx_d      = idx_q;
    valid_d    = valid_q;
    data_d     = data_q;
    eop_d      = eop_q;
    if (valid_q && out_ready) valid_d = 1'b0;
    if (start) begin
      active_d = 1'b1;
      idx_d    = '0;
    end
    if (issue) begin
      idx_d      = idx_q + SEQ_W'(1);
      inflight_d = 1'b1;
      sel_row_d  = is_row;
      last_d     = (idx_q == total - SEQ_W'(1));
    end
    if (inflight_q) begin
      valid_d    = 1'b1;
      data_d     = sel_row_q ? row_sum : col_sum;
      eop_d      = last_q;
      inflight_d = 1'b0;
    end
    if (finished) active_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      inflight_q <= 1'b0;
      sel_row_q  <= 1'b0;
      last_q     <= 1'b0;
      idx_q      <= '0;
      valid_q    <= 1'b0;
      data_q     <= '0;
      eop_q      <= 1'b0;
    end else begin
      active_q   <= active_d;
      inflight_q <= inflight_d;
      sel_row_q  <= sel_row_d;
      last_q     <= last_d;
      idx_q      <= idx_d;
      valid_q    <= valid_d;
      data_q     <= data_d;
      eop_q      <= eop_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_eop   = eop_q;

  // R8: a stalled beat holds its content.
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eop)));

  // R3: the end-of-packet beat comes only after all W+H reads were issued.
  p_eop_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eop) |-> (idx_q == total));

endmodule

// File: rtl/prof_profiler.sv
module prof_profiler import prof_pkg::*; #(
  parameter int PIX_W   = 16,
  parameter int MAX_DIM = 256,
  localparam int IDX_W  = $clog2(MAX_DIM),
  localparam int DIM_W  = IDX_W + 1,
  localparam int CNT_W  = 2 * DIM_W,
  localparam int ACC_W  = acc_width(PIX_W, MAX_DIM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIM_W-1:0] cfg_width,
  input  logic [DIM_W-1:0] cfg_height,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ACC_W-1:0] out_data,
  output logic             out_eop,
  output logic             done,
  output logic             frame_short
);

  prof_state_e      state_q, state_d;
  logic [DIM_W-1:0] w_q, w_d, h_q, h_d, col_q, col_d, row_q, row_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_next, area, pos_cnt;
  logic             short_q, short_d, done_q, done_d;
  logic             fire, sop_fire, pix_ok, acc_en, last_col, row_end;
  logic [DIM_W-1:0] w_eff, h_eff, pos_col, pos_row;
  logic             emit_start, emit_fin, col_rd_en, row_rd_en;
  logic [IDX_W-1:0] rd_idx;
  logic [ACC_W-1:0] col_sum, row_sum;

  assign in_ready = (state_q == ST_IDLE) || (state_q == ST_FRAME);
  assign fire     = in_valid && in_ready;
  assign sop_fire = fire && in_sop;
  assign pix_ok   = fire && (in_sop || (state_q == ST_FRAME));
  assign w_eff    = in_sop ? cfg_width  : w_q;
  assign h_eff    = in_sop ? cfg_height : h_q;
  assign pos_col  = in_sop ? '0 : col_q;
  assign pos_row  = in_sop ? '0 : row_q;
  assign pos_cnt  = in_sop ? '0 : cnt_q;
  assign cnt_next = pos_cnt + CNT_W'(1);
  assign area     = CNT_W'(w_eff) * CNT_W'(h_eff);
  assign acc_en   = pix_ok && (pos_row < h_eff);
  assign last_col = (pos_col == w_eff - DIM_W'(1));
  assign row_end  = last_col || in_eop;
  assign emit_start = (state_q == ST_DRAIN);

  always_comb begin
    state_d = state_q;
    w_d     = w_q;
    h_d     = h_q;
    col_d   = col_q;
    row_d   = row_q;
    cnt_d   = cnt_q;
    short_d = short_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE, ST_FRAME: begin
        if (pix_ok) begin
          if (in_sop) begin
            w_d     = cfg_width;
            h_d     = cfg_height;
            short_d = 1'b0;
          end
          if (pos_row < h_eff) begin
            if (last_col) begin
              col_d = '0;
              row_d = pos_row + DIM_W'(1);
            end else begin
              col_d = pos_col + DIM_W'(1);
              row_d = pos_row;
            end
          end
          cnt_d = cnt_next;
          if (in_eop) begin
            state_d = ST_DRAIN;
            short_d = cnt_next < area;
          end else begin
            state_d = ST_FRAME;
          end
        end
      end
      ST_DRAIN: state_d = ST_EMIT;
      ST_EMIT: begin
        if (emit_fin) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      w_q     <= DIM_W'(1);
      h_q     <= DIM_W'(1);
      col_q   <= '0;
      row_q   <= '0;
      cnt_q   <= '0;
      short_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      w_q     <= w_d;
      h_q     <= h_d;
      col_q   <= col_d;
      row_q   <= row_d;
      cnt_q   <= cnt_d;
      short_q <= short_d;
      done_q  <= done_d;
    end
  end

  prof_col_acc #(.PIX_W(PIX_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) i_col (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (sop_fire),
    .acc_en  (acc_en),
    .acc_idx (IDX_W'(pos_col)),
    .acc_pix (in_data),
    .rd_en   (col_rd_en),
    .rd_idx  (rd_idx),
    .rd_sum  (col_sum)
  );

  prof_row_acc #(.PIX_W(PIX_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) i_row (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (sop_fire),
    .acc_en  (acc_en),
    .acc_row (IDX_W'(pos_row)),
    .acc_pix (in_data),
    .row_end (row_end),
    .rd_en   (row_rd_en),
    .rd_idx  (rd_idx),
    .rd_sum  (row_sum)
  );

  prof_emit #(.ACC_W(ACC_W), .IDX_W(IDX_W)) i_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (emit_start),
    .width     (w_q),
    .height    (h_q),
    .col_rd_en (col_rd_en),
    .row_rd_en (row_rd_en),
    .rd_idx    (rd_idx),
    .col_sum   (col_sum),
    .row_sum   (row_sum),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_eop   (out_eop),
    .finished  (emit_fin)
  );

  assign done        = done_q;
  assign frame_short = short_q;

  // R4: input is closed whenever a profile beat is on the output.
  p_ready_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R9: completion pulse lasts one cycle.
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: completion follows the accepted last beat.
  p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready && out_eop));

endmodule

// File: tb/test_prof_profiler.sv
module test_prof_profiler;

  localparam int MAXD = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [8:0]  cfg_width, cfg_height;
  logic        in_valid, in_ready, in_sop, in_eop;
  logic [15:0] in_data;
  logic        out_valid, out_ready, out_eop, done, frame_short;
  logic [23:0] out_data;

  int total = 0;
  int bad = 0;
  bit fin = 1'b0;
  longint exp_col [MAXD];
  longint exp_row [MAXD];

  always #4 clk = ~clk;

  prof_profiler i_prof_profiler (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_eop(out_eop),
    .done(done), .frame_short(frame_short)
  );

  task automatic chk(bit ok, string req, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Starts and ends one time unit after a rising edge.
  task automatic send_pix(logic [15:0] d, bit sop, bit eop);
    in_valid = 1'b1;
    in_data  = d;
    in_sop   = sop;
    in_eop   = eop;
    @(negedge clk);
    chk(in_ready == 1'b1, "R4 ready during frame", in_ready, 1);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_eop   = 1'b0;
  endtask

  task automatic collect(int w, int h, bit exp_short);
    int idx = 0;
    bit hold_pending = 1'b0;
    logic [23:0] held = '0;
    longint expv;
    while (idx < w + h) begin
      out_ready = (($urandom % 100) < 65);
      @(negedge clk);
      chk(in_ready == 1'b0, "R4 stalled during emission", in_ready, 0);
      if (hold_pending) begin
        chk(out_valid && (out_data == held), "R8 hold", out_data, held);
        hold_pending = 1'b0;
      end
      if (out_valid) begin
        if (out_ready) begin
          if (idx < w) begin
            expv = exp_col[idx];
            chk(out_data == expv[23:0], "R1 column sum", out_data, expv);
          end else begin
            expv = exp_row[idx - w];
            chk(out_data == expv[23:0], "R2 row sum", out_data, expv);
          end
          chk(out_eop == (idx == w + h - 1), "R3 eop position", out_eop, idx == w + h - 1);
          idx++;
        end else begin
          held = out_data;
          hold_pending = 1'b1;
        end
      end
      @(posedge clk);
      #1;
    end
    out_ready = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, "R9 done after last beat", done, 1);
    chk(in_ready == 1'b1, "R4 ready after emission", in_ready, 1);
    chk(frame_short == exp_short, "R7 short flag", frame_short, exp_short);
    @(posedge clk);
    #1;
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);
    chk(out_valid == 1'b0, "R3 no extra beat", out_valid, 0);
    @(posedge clk);
    #1;
  endtask

  task automatic run_frame(int w, int h, int npix, bit maxval, int gap_pct);
    logic [15:0] d;
    foreach (exp_col[i]) begin
      exp_col[i] = 0;
      exp_row[i] = 0;
    end
    cfg_width  = 9'(w);
    cfg_height = 9'(h);
    for (int k = 0; k < npix; k++) begin
      d = maxval ? 16'hFFFF : 16'($urandom);
      if (k < w * h) begin
        exp_col[k % w] += d;
        exp_row[k / w] += d;
      end
      if (($urandom % 100) < gap_pct) idle(1 + ($urandom % 3));
      send_pix(d, k == 0, k == npix - 1);
    end
    collect(w, h, npix < w * h);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int b0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
    out_ready = 1'b0; cfg_width = 9'd4; cfg_height = 9'd3;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R11 reset in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R11 reset out_valid", out_valid, 0);
    chk(done == 1'b0, "R11 reset done", done, 0);
    chk(frame_short == 1'b0, "R11 reset frame_short", frame_short, 0);
    @(posedge clk);
    #1;

    // R10: stray beats while idle, one of them with end-of-packet.
    b0 = bad;
    send_pix(16'h1234, 1'b0, 1'b0);
    send_pix(16'h4321, 1'b0, 1'b1);
    idle(4);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 no emission from stray eop", out_valid, 0);
    chk(in_ready == 1'b1, "R10 still ready", in_ready, 1);
    @(posedge clk);
    #1;
    run_frame(4, 3, 12, 1'b0, 0);
    chk(bad == b0, "R10 stray beats left sums intact", bad - b0, 0);

    // Random frames with random gaps and back-pressure.
    for (int f = 0; f < 25; f++) begin
      int w = 1 + ($urandom % 24);
      int h = 1 + ($urandom % 24);
      run_frame(w, h, w * h, 1'b0, 20);
    end

    // R5: a single column, every pixel hits the same accumulator.
    b0 = bad;
    run_frame(1, 40, 40, 1'b0, 0);
    run_frame(1, 256, 256, 1'b1, 0);
    chk(bad == b0, "R5 same-column accumulation", bad - b0, 0);

    // Widest frame with full-scale pixels (R2 row sum limit).
    run_frame(256, 2, 512, 1'b1, 0);
    run_frame(1, 1, 1, 1'b0, 0);

    // R6: frame restarted by a fresh start-of-packet.
    b0 = bad;
    cfg_width = 9'd3;
    cfg_height = 9'd3;
    send_pix(16'hAAAA, 1'b1, 1'b0);
    for (int k = 0; k < 7; k++) send_pix(16'h7777, 1'b0, 1'b0);
    run_frame(5, 4, 20, 1'b0, 10);
    chk(bad == b0, "R6 restart discards old sums", bad - b0, 0);

    // R7: short frames, then a full one clearing the flag.
    b0 = bad;
    run_frame(6, 5, 13, 1'b0, 0);
    run_frame(10, 3, 4, 1'b1, 0);
    chk(bad == b0, "R7 short frames emitted with zero fill", bad - b0, 0);
    run_frame(7, 2, 14, 1'b0, 30);

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule